// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block keeps the single reservation that an atomic read-modify-write sequence relies on. A reserving load presents its two address operands. The block forms the effective address, records it and marks the reservation as held. A later conditional store forms its own effective address and checks whether a reservation is held. If one is held, the block issues a full-word memory write and reports success. If none is held, no write goes out and failure is reported. In both cases the reservation is dropped.

The outcome comes back one clock after the conditional-store strobe. It consists of a done pulse, a success flag that the condition-register update consumes, and the write request itself. A conditional store that succeeds against a word other than the reserved one still writes. It raises a mismatch indication next to the write.

Top module: `resv_tracker`

## Requirements
- R1: The effective address is `rb_val_i` when `ra_zero_i` is 1 and `ra_val_i + rb_val_i` (modulo 2^32) otherwise. A successful conditional store drives exactly this value on `wr_addr_o`.
- R2: A conditional store (`cstore_i`=1) made while the reservation is held produces, on the next clock, `done_o`=1, `success_o`=1 and `wr_req_o`=1.
- R3: A conditional store made while no reservation is held produces, on the next clock, `done_o`=1, `success_o`=0 and `wr_req_o`=0.
- R4: Every conditional store drops the reservation, whether it succeeds or fails. A second conditional store with no reserve in between therefore fails.
- R5: `mismatch_o` is 1 with a successful write when bits [31:2] of the store address differ from those of the reserved address. It is 0 when they are equal and 0 whenever the store fails.
- R6: A reserve (`reserve_i`=1) marks the reservation held and replaces any earlier reserved address with its own effective address.
- R7: A write request lasts one clock per conditional store. It carries `store_data_i` on `wr_data_o` and `wr_be_o`=4'b1111.
- R8: Reset (`rst_n`=0) drops the reservation and holds all outputs at 0.
- R9: When reserve and conditional store arrive in the same clock, the store is judged against the reservation state from before that clock. The reserve then leaves a fresh reservation held at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ra_zero_i | input | 1 | The base register field is zero: use the index operand alone |
| ra_val_i | input | 32 | Base operand value |
| rb_val_i | input | 32 | Index operand value |
| reserve_i | input | 1 | Reserving-load strobe |
| cstore_i | input | 1 | Conditional-store strobe |
| store_data_i | input | 32 | Word to store |
| wr_req_o | output | 1 | Memory write request pulse |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_be_o | output | 4 | Write byte enables |
| success_o | output | 1 | Conditional store succeeded |
| done_o | output | 1 | Conditional-store result valid |
| mismatch_o | output | 1 | Successful store hit a word other than the reserved one |

## Verification
The assertions watch every cycle for the properties that tie one clock to the next. A reserve always leaves the reservation held. A store without a reserve always drops it. A store always yields a done pulse whose write request agrees with the success flag. A failed store never signals a mismatch, and every write carries full byte enables. Only the bench's scenarios can show what needs history across several operations. These include a second store failing after the first consumed the reservation, a later reserve replacing an earlier address, the mismatch decision against a specific reserved word, and the same-clock ordering of reserve and store.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // Kind of request presented in one clock
  typedef enum logic [1:0] {
    REQ_IDLE    = 2'b00,
    REQ_RESERVE = 2'b01,
    REQ_STORE   = 2'b10,
    REQ_BOTH    = 2'b11
  } req_kind_e;

  function automatic req_kind_e classify(input logic reserve, input logic cstore);
    return req_kind_e'({cstore, reserve});
  endfunction
endpackage

// File: rtl/resv_ea_calc.sv
module resv_ea_calc #(
  parameter int ADDR_W = 32
) (
  input  logic              ra_zero_i,
  input  logic [ADDR_W-1:0] ra_val_i,
  input  logic [ADDR_W-1:0] rb_val_i,
  output logic [ADDR_W-1:0] ea_o
);
  // R1: the base operand is dropped when its register field is zero
  function automatic logic [ADDR_W-1:0] form_ea(input logic zero,
                                                input logic [ADDR_W-1:0] a,
                                                input logic [ADDR_W-1:0] b);
    return zero ? b : a + b;
  endfunction

  always_comb ea_o = form_ea(ra_zero_i, ra_val_i, rb_val_i);
endmodule

// File: rtl/resv_slot.sv
module resv_slot #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              consume_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic              held_o,
  output logic              same_gran_o
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;

  logic             held_q;
  logic [TAG_W-1:0] tag_q;

  function automatic logic [TAG_W-1:0] gran_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GRAN_LSB];
  endfunction

  // R6 / R4 / R9: a reserve wins over the consume of the same clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      tag_q  <= '0;
    end else if (take_i) begin
      held_q <= 1'b1;
      tag_q  <= gran_tag(ea_i);
    end else if (consume_i) begin
      held_q <= 1'b0;
    end
  end

  assign held_o      = held_q;
  assign same_gran_o = (gran_tag(ea_i) == tag_q);

  a_r6_reserve_holds: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> held_o);
  a_r4_store_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_i && !take_i) |=> !held_o);
  a_r8_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume_i && !take_i) |=> held_o == $past(held_o));
endmodule

// File: rtl/resv_store_ctrl.sv
module resv_store_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cstore_i,
  input  logic              held_i,
  input  logic              same_gran_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W/8-1:0] wr_be_o,
  output logic              success_o,
  output logic              done_o,
  output logic              mismatch_o
);
  localparam int BE_W = DATA_W / 8;

  logic fire_w;
  logic stray_w;

  assign fire_w  = cstore_i && held_i;
  assign stray_w = fire_w && !same_gran_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      wr_be_o    <= '0;
      success_o  <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      wr_req_o   <= fire_w;
      success_o  <= fire_w;
      done_o     <= cstore_i;
      mismatch_o <= stray_w;
      wr_be_o    <= fire_w ? {BE_W{1'b1}} : '0;
      if (fire_w) begin
        wr_addr_o <= ea_i;
        wr_data_o <= data_i;
      end
    end
  end

  a_r2_write_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cstore_i && held_i) |=> (done_o && success_o && wr_req_o));
  a_r3_no_write_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (cstore_i && !held_i) |=> (done_o && !success_o && !wr_req_o));
  a_r7_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> wr_be_o == {BE_W{1'b1}});
  a_r7_req_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> done_o);
  a_r5_no_flag_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    !success_o |-> !mismatch_o);
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ra_zero_i,
  input  logic [ADDR_W-1:0] ra_val_i,
  input  logic [ADDR_W-1:0] rb_val_i,
  input  logic              reserve_i,
  input  logic              cstore_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W/8-1:0] wr_be_o,
  output logic              success_o,
  output logic              done_o,
  output logic              mismatch_o
);
  import resv_pkg::*;

  logic [ADDR_W-1:0] ea_w;
  logic              held_w;
  logic              same_gran_w;
  req_kind_e         kind_w;
  logic              take_w;
  logic              consume_w;

  assign kind_w    = classify(reserve_i, cstore_i);
  assign take_w    = (kind_w == REQ_RESERVE) || (kind_w == REQ_BOTH);
  assign consume_w = (kind_w == REQ_STORE)   || (kind_w == REQ_BOTH);

  resv_ea_calc #(.ADDR_W(ADDR_W)) ea_i (
    .ra_zero_i (ra_zero_i),
    .ra_val_i  (ra_val_i),
    .rb_val_i  (rb_val_i),
    .ea_o      (ea_w)
  );

  resv_slot #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) slot_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_w),
    .consume_i   (consume_w),
    .ea_i        (ea_w),
    .held_o      (held_w),
    .same_gran_o (same_gran_w)
  );

  resv_store_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) st_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cstore_i    (consume_w),
    .held_i      (held_w),
    .same_gran_i (same_gran_w),
    .ea_i        (ea_w),
    .data_i      (store_data_i),
    .wr_req_o    (wr_req_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_be_o     (wr_be_o),
    .success_o   (success_o),
    .done_o      (done_o),
    .mismatch_o  (mismatch_o)
  );

  // R9: a same-clock pair is judged on the old state and leaves a fresh hold
  a_r9_pair_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (reserve_i && cstore_i) |=> (done_o && held_w));
endmodule

// File: tb/resv_tracker_tb.sv
module resv_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ra_zero = 1'b0;
  logic [31:0] ra = '0, rb = '0, sd = '0;
  logic        res = 1'b0, cs = 1'b0;
  logic        wr_req, success, done, mismatch;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  resv_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .ra_zero_i(ra_zero), .ra_val_i(ra), .rb_val_i(rb),
    .reserve_i(res), .cstore_i(cs), .store_data_i(sd),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be),
    .success_o(success), .done_o(done), .mismatch_o(mismatch)
  );

  // Behavioural reference: a held flag and a reserved word number
  bit          m_held = 0;
  longint      m_word = 0;
  bit          e_req = 0, e_succ = 0, e_done = 0, e_mis = 0;
  longint      e_addr = 0, e_data = 0;

  always @(posedge clk) begin
    longint ea;
    ea = ra_zero ? longint'(rb) : (longint'(ra) + longint'(rb)) % 64'h1_0000_0000;
    if (!rst_n) begin
      m_held = 0; e_req = 0; e_succ = 0; e_done = 0; e_mis = 0;
    end else begin
      e_done = cs;
      e_req  = cs && m_held;
      e_succ = e_req;
      e_mis  = e_req && ((ea / 4) != m_word);
      if (e_req) begin e_addr = ea; e_data = longint'(sd); end
      if (res) begin m_held = 1; m_word = ea / 4; end
      else if (cs) m_held = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == e_done, "R2 done", done, e_done);
      chk(wr_req == e_req, "R3 wr_req", wr_req, e_req);
      chk(success == e_succ, "R2 success", success, e_succ);
      chk(mismatch == e_mis, "R5 mismatch", mismatch, e_mis);
      if (e_req) begin
        chk(longint'(wr_addr) == e_addr, "R1 addr", wr_addr, e_addr);
        chk(longint'(wr_data) == e_data, "R7 data", wr_data, e_data);
        chk(wr_be == 4'hF, "R7 be", wr_be, 4'hF);
      end
    end
  end

  task automatic step(input bit r, input bit c, input bit z,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] d);
    res = r; cs = c; ra_zero = z; ra = a; rb = b; sd = d;
    @(posedge clk);
    @(negedge clk);
    res = 0; cs = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs idle in reset
    chk({wr_req, success, done, mismatch} == 4'b0, "R8 reset outputs", {wr_req, success, done, mismatch}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: a store right after reset fails
    step(0, 1, 0, 32'h100, 32'h4, 32'h11);
    chk(done && !success && !wr_req, "R8 no hold after reset", success, 0);
    // R1/R2: reserve then store to same base+index
    step(1, 0, 0, 32'h1000, 32'h20, 0);
    step(0, 1, 0, 32'h1000, 32'h20, 32'hCAFE_0001);
    chk(wr_req && success, "R2 success after reserve", success, 1);
    chk(wr_addr == 32'h1020, "R1 base plus index", wr_addr, 32'h1020);
    chk(!mismatch, "R5 same word no flag", mismatch, 0);
    // R7: single-clock pulse
    @(negedge clk);
    chk(!wr_req, "R7 one clock pulse", wr_req, 0);
    // R4: second store fails
    step(0, 1, 0, 32'h1000, 32'h20, 32'h2);
    chk(!success && !wr_req && done, "R4 consumed on success", success, 0);
    // R3: failed store also consumes; still fails afterwards
    step(0, 1, 0, 32'h0, 32'h0, 32'h3);
    chk(!success, "R3 fail without hold", success, 0);
    // R1: base field zero uses index alone
    step(1, 0, 1, 32'hFFFF_0000, 32'h40, 0);
    step(0, 1, 1, 32'hFFFF_0000, 32'h40, 32'h44);
    chk(wr_addr == 32'h40 && !mismatch, "R1 zero base", wr_addr, 32'h40);
    // R6: later reserve replaces earlier address
    step(1, 0, 0, 32'h200, 32'h0, 0);
    step(1, 0, 0, 32'h300, 32'h0, 0);
    step(0, 1, 0, 32'h300, 32'h2, 32'h55);
    chk(success && !mismatch, "R6 replaced address", mismatch, 0);
    // R5: store elsewhere still writes and flags
    step(1, 0, 0, 32'h500, 32'h0, 0);
    step(0, 1, 0, 32'h504, 32'h0, 32'h66);
    chk(wr_req && mismatch && wr_addr == 32'h504, "R5 stray write", mismatch, 1);
    // R9: pair with no prior hold fails, then leaves a hold
    step(1, 1, 0, 32'h700, 32'h0, 32'h77);
    chk(done && !success, "R9 pair judged on old state", success, 0);
    step(0, 1, 0, 32'h700, 32'h0, 32'h78);
    chk(success && !mismatch, "R9 pair rearms", success, 1);
    // Mixed traffic against the reference
    for (int i = 0; i < 400; i++) begin
      res = ($urandom % 3) == 0; cs = ($urandom % 3) == 0; ra_zero = ($urandom % 4) == 0;
      ra = {28'h0, 4'($urandom)}; rb = {28'h0, 4'($urandom)}; sd = $urandom;
      @(negedge clk);
    end
    res = 0; cs = 0;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule